// File: doc/BRIEF.md
# Byte Serial Port Controller with Master and Slave Modes

This block moves one byte at a time over a four-wire synchronous serial link. The CPU side sees two byte-wide registers on a simple write/read bus: a control/status register and a data register. The data register is also the shift register. In master mode a write to it starts an exchange. The block then makes the serial clock from the system clock, using a selectable pre-divider and baud divider. It shifts the byte out and shifts the reply in.

In slave mode the serial clock comes from outside. It is brought into the system clock domain through two flops. The shift register follows its edges, optionally only while an active-low select input is asserted. Data is driven after falling clock edges and sampled on rising ones. Either bit order can be chosen. A completion flag drives the interrupt output. A data write during an exchange is dropped and flagged as a collision. Output-enable signals for the clock and data pins are block outputs, so the pin wrapper can tri-state the lines while the port is off.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, `irq` is 0, and `sck_oe` and `sdo_oe` are 0.
- R2: Control bit 4 enables the port. While it is 0, `sck_oe` and `sdo_oe` are 0. While it is 1, `sdo_oe` is 1, `sck_oe` is 1 in master modes, and `sck_o` stays low whenever no exchange is running.
- R3: In a master mode, a data-register write (address 1) while idle starts an exchange of 8 bits. Afterwards the data register (address 1) reads the byte received on `sdi_i`.
- R4: Control bits 6:5 set the mode: 00 is master at base/4, 01 is master at base/16, 10 is master at base/64, and 11 is slave. Control bit 7 sets the base: 0 means the system clock, 1 means the system clock divided by 4. The serial clock half period is half the total divisor. The complete flag sets exactly 16 half periods after the write edge.
- R5: Output data changes only when the serial clock falls or when an exchange is loaded. The input is sampled when the serial clock rises.
- R6: Control bit 3 = 1 shifts MSB first and bit 3 = 0 shifts LSB first. This holds for both transmit and receive.
- R7: When an exchange ends, control bit 0 (complete) is set, and `irq` is high while it is set.
- R8: A data write during an exchange sets control bit 1 (collision) and leaves both the byte in flight and the result unchanged.
- R9: Writing 0 to control bit 0 or bit 1 clears that flag. Writing 1 to either leaves it unchanged.
- R10: In slave mode (11) the byte shifts on the synchronized external clock: in on its rising edges, out after its falling edges. The exchange completes after the 8th falling edge.
- R11: With control bit 2 = 1, slave shifting happens only while `ss_n_i` is low, and raising `ss_n_i` discards a partial bit count. With bit 2 = 0, `ss_n_i` is ignored.
- R12: A data write while the port is disabled loads the register but starts no exchange, and the serial clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control/status, 1 selects data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | High while the complete flag is set |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock pin drive enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data pin drive enable |
| ss_n_i | input | 1 | Active-low slave select input |

## Verification
The master engine is swept over all 256 transmit bytes in both bit orders at the fastest rate. The reply byte is the bitwise inverse of the transmitted one, so a loop-back fault or a swapped shift direction shows up as a wrong value. Every master divisor setting is timed separately, which separates a wrong pre-divider from a wrong baud field. The slave path runs on a slow external clock in both orders, with select qualification enabled and disabled. One slave exchange is interrupted by deselecting partway through, which tells a counter that restarts apart from one that resumes. Collision, flag clearing and disabled-write cases each have a dedicated sequence.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [1:0] {
    MODE_M4   = 2'b00,
    MODE_M16  = 2'b01,
    MODE_M64  = 2'b10,
    MODE_SLV  = 2'b11
  } port_mode_e;

  // Half period of the serial clock in system cycles.
  function automatic int unsigned sck_half(input logic pre4, input logic [1:0] mode);
    int unsigned pre;
    int unsigned baud;
    pre  = pre4 ? 4 : 1;
    baud = 4 << (2 * mode);
    return (pre * baud) / 2;
  endfunction

  // Next shift register value: one bit leaves, the captured bit enters.
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic msb_first,
                                          input logic bit_in);
    return msb_first ? {cur[6:0], bit_in} : {bit_in, cur[7:1]};
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + HW'(1);
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(half) |-> cnt < half);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              msb_first,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  input  logic              s_rise,
  input  logic              s_fall,
  input  logic              s_active,
  output logic [DATA_W-1:0] sr_q,
  output logic              sdo,
  output logic              sck_m,
  output logic              m_run,
  output logic              busy,
  output logic              done_evt
);
  import spi_pkg::*;
  localparam int BCW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sr;
  logic [BCW-1:0]    cnt;
  logic              rbit, mbusy, sbusy, sck_q;
  logic              last, m_rise_evt, m_fall_evt, s_rise_evt, s_fall_evt, shift_evt;
  logic [DATA_W-1:0] sr_next;

  assign last       = (cnt == BCW'(DATA_W - 1));
  assign m_rise_evt = en && master && mbusy && tick && !sck_q;
  assign m_fall_evt = en && master && mbusy && tick && sck_q;
  assign s_rise_evt = en && !master && s_active && s_rise;
  assign s_fall_evt = en && !master && s_active && s_fall && sbusy;
  assign shift_evt  = m_fall_evt || s_fall_evt;
  assign done_evt   = shift_evt && last;
  assign sr_next    = shift_in(sr, msb_first, rbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; rbit <= 1'b0;
      mbusy <= 1'b0; sbusy <= 1'b0; sck_q <= 1'b0;
    end else begin
      if (load) sr <= load_data;
      if (!en) begin
        mbusy <= 1'b0; sbusy <= 1'b0; sck_q <= 1'b0; cnt <= '0;
      end else if (master) begin
        sbusy <= 1'b0;
        if (load) begin
          mbusy <= 1'b1; sck_q <= 1'b0; cnt <= '0;
        end else if (m_rise_evt) begin
          sck_q <= 1'b1; rbit <= sdi;
        end else if (m_fall_evt) begin
          sck_q <= 1'b0; sr <= sr_next;
          cnt   <= last ? '0 : cnt + BCW'(1);
          if (last) mbusy <= 1'b0;
        end
      end else begin
        mbusy <= 1'b0; sck_q <= 1'b0;
        if (!s_active) begin
          sbusy <= 1'b0; cnt <= '0;
        end else if (s_rise_evt) begin
          rbit <= sdi; sbusy <= 1'b1;
        end else if (s_fall_evt) begin
          sr  <= sr_next;
          cnt <= last ? '0 : cnt + BCW'(1);
          if (last) sbusy <= 1'b0;
        end
      end
    end
  end

  assign sr_q  = sr;
  assign sdo   = msb_first ? sr[DATA_W-1] : sr[0];
  assign sck_m = sck_q;
  assign m_run = mbusy;
  assign busy  = mbusy || sbusy;

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) && $stable(msb_first) |-> $stable(sdo));
  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < BCW'(DATA_W));
  // R11
  desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !master && !s_active |=> cnt == '0 && !sbusy);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DATA_W    = 8,
  parameter int MAX_HALF  = 128,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i
);
  import spi_pkg::*;
  localparam int HW = $clog2(MAX_HALF) + 1;

  // control fields
  logic       pre4, en, msbf, sel_en, wcol, trf;
  port_mode_e mode;
  logic       master;

  // events and datapath
  logic              busy, done_evt, tick, m_run, sck_m, sdo_w;
  logic              data_wr, load, collide;
  logic [DATA_W-1:0] sr_q;
  logic [HW-1:0]     half;
  logic [1:0]        sync_q;
  logic              sck_s, ss_s, sck_prev, s_rise, s_fall, s_active;
  logic [7:0]        ctrl_rd;

  assign master  = (mode != MODE_SLV);
  assign data_wr = reg_wr && reg_addr;
  assign load    = data_wr && !busy;
  assign collide = data_wr && busy;
  assign half    = HW'(sck_half(pre4, mode));

  spi_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i}), .q(sync_q));

  assign sck_s    = sync_q[0];
  assign ss_s     = sync_q[1];
  assign s_rise   = sck_s && !sck_prev;
  assign s_fall   = !sck_s && sck_prev;
  assign s_active = !sel_en || !ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  spi_baud #(.HW(HW)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(m_run), .half(half), .tick(tick));

  spi_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .msb_first(msbf),
    .tick(tick), .load(load), .load_data(reg_wdata), .sdi(sdi_i),
    .s_rise(s_rise), .s_fall(s_fall), .s_active(s_active),
    .sr_q(sr_q), .sdo(sdo_w), .sck_m(sck_m), .m_run(m_run),
    .busy(busy), .done_evt(done_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre4 <= 1'b0; mode <= MODE_M4; en <= 1'b0; msbf <= 1'b0;
      sel_en <= 1'b0; wcol <= 1'b0; trf <= 1'b0;
    end else begin
      if (reg_wr && !reg_addr) begin
        pre4   <= reg_wdata[7];
        mode   <= port_mode_e'(reg_wdata[6:5]);
        en     <= reg_wdata[4];
        msbf   <= reg_wdata[3];
        sel_en <= reg_wdata[2];
        if (!reg_wdata[1]) wcol <= 1'b0;
        if (!reg_wdata[0]) trf  <= 1'b0;
      end
      if (collide)  wcol <= 1'b1;
      if (done_evt) trf  <= 1'b1;
    end
  end

  assign ctrl_rd   = {pre4, mode, en, msbf, sel_en, wcol, trf};
  assign reg_rdata = reg_addr ? sr_q : DATA_W'(ctrl_rd);
  assign irq       = trf;
  assign sck_o     = sck_m;
  assign sck_oe    = en && master;
  assign sdo_o     = en && sdo_w;
  assign sdo_oe    = en;

  // R8
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol);
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> trf && irq);
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_o);
  // R12
  off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  // R4
  sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !$stable(sck_o) |-> $past(tick));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, sck_oe, sdo_o, sdo_oe;
  logic       sck_i = 1'b0;
  logic       ss_n_i = 1'b1;
  logic       sdi_s = 1'b0;
  logic       sdi_i;

  int nchk = 0;
  int nfail = 0;

  // bench-side peer for master exchanges
  logic       use_model = 1'b0;
  logic [7:0] sb = 8'h00;
  logic       sb_msbf = 1'b1;
  int         sidx = 0;
  logic [7:0] cap = 8'h00;
  logic       model_bit;
  logic [7:0] ctrl_cur = 8'h00;

  assign model_bit = (sidx > 7) ? 1'b0 : (sb_msbf ? sb[7 - sidx] : sb[sidx]);
  assign sdi_i     = use_model ? model_bit : sdi_s;

  always #2.5 clk = ~clk;

  always @(negedge sck_o) if (use_model) sidx = sidx + 1;
  always @(posedge sck_o) if (use_model)
    cap = sb_msbf ? {cap[6:0], sdo_o} : {sdo_o, cap[7:1]};

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_n_i(ss_n_i));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg(input bit pre4, input bit [1:0] md, input bit en,
                                     input bit msbf, input bit sel);
    return {pre4, md, en, msbf, sel, 2'b00};
  endfunction

  function automatic int exp_half(input bit pre4, input bit [1:0] md);
    int d;
    d = (md == 2'd0) ? 4 : (md == 2'd1) ? 16 : 64;
    if (pre4) d = d * 4;
    return d / 2;
  endfunction

  task automatic wr_reg(input bit a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input bit a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_cfg(input logic [7:0] c);
    ctrl_cur = c;
    wr_reg(1'b0, c);
  endtask

  // One master exchange; returns after the complete flag is seen.
  task automatic mxfer(input logic [7:0] tx, input logic [7:0] rxb, input bit msbf,
                       input int expc, input bit check_time);
    logic [7:0] rd;
    int n;
    use_model = 1'b1; sb = rxb; sb_msbf = msbf; sidx = 0; cap = 8'h00;
    wr_reg(1'b1, tx);
    n = 0;
    while (!irq && n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    if (check_time) chk(n == expc, "R4 transfer length", n, expc);
    rd_reg(1'b0, rd);
    chk(rd[0] == 1'b1 && irq == 1'b1, "R7 complete flag and irq", {rd[0], irq}, 2'b11);
    rd_reg(1'b1, rd);
    chk(rd == rxb, "R3 received byte", rd, rxb);
    chk(cap == tx, "R6 transmitted order", cap, tx);
    chk(sck_o == 1'b0, "R2 clock idles low", sck_o, 0);
    set_cfg(ctrl_cur);
    use_model = 1'b0;
  endtask

  // Slave bits k0 .. k0+nb-1 of rx, recording sdo before each rising clock.
  task automatic sbits(input int k0, input int nb, input logic [7:0] rx, input bit msbf,
                       inout logic [7:0] got);
    for (int k = k0; k < k0 + nb; k++) begin
      sdi_s = msbf ? rx[7 - k] : rx[k];
      repeat (6) @(negedge clk);
      got = msbf ? {got[6:0], sdo_o} : {sdo_o, got[7:1]};
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      sck_i = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(1'b0, rd);
    chk(rd == 8'h00, "R1 control after reset", rd, 0);
    chk(irq == 1'b0 && sck_oe == 1'b0 && sdo_oe == 1'b0, "R1 pins after reset",
        {irq, sck_oe, sdo_oe}, 0);

    // R12 data write while disabled
    wr_reg(1'b1, 8'h6E);
    repeat (40) begin
      @(negedge clk);
      chk(sck_o == 1'b0 && irq == 1'b0, "R12 no exchange while disabled", {sck_o, irq}, 0);
    end
    rd_reg(1'b1, rd);
    chk(rd == 8'h6E, "R12 register loaded", rd, 8'h6E);

    // R2 enabling drives pins, clock stays idle
    set_cfg(cfg(1'b0, 2'd0, 1'b1, 1'b1, 1'b0));
    repeat (20) @(negedge clk);
    chk(sck_oe == 1'b1 && sdo_oe == 1'b1 && sck_o == 1'b0, "R2 enabled master pins",
        {sck_oe, sdo_oe, sck_o}, 3'b110);

    // R4 every divisor setting
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 3; m++) begin
        set_cfg(cfg(p[0], m[1:0], 1'b1, 1'b1, 1'b0));
        mxfer(8'h5A, 8'hC3, 1'b1, 16 * exp_half(p[0], m[1:0]), 1'b1);
      end

    // R3 R5 R6 full byte sweep in both orders at the fastest rate
    for (int o = 0; o < 2; o++) begin
      set_cfg(cfg(1'b0, 2'd0, 1'b1, o[0], 1'b0));
      for (int v = 0; v < 256; v++)
        mxfer(v[7:0], ~v[7:0], o[0], 32, 1'b1);
    end

    // R8 collision
    set_cfg(cfg(1'b0, 2'd1, 1'b1, 1'b1, 1'b0));
    use_model = 1'b1; sb = 8'h81; sb_msbf = 1'b1; sidx = 0; cap = 8'h00;
    wr_reg(1'b1, 8'hA5);
    wr_reg(1'b1, 8'h3C);
    rd_reg(1'b0, rd);
    chk(rd[1] == 1'b1, "R8 collision flag", rd[1], 1);
    while (!irq) @(negedge clk);
    rd_reg(1'b1, rd);
    chk(rd == 8'h81, "R8 result unchanged by collision", rd, 8'h81);
    chk(cap == 8'hA5, "R8 byte in flight unchanged", cap, 8'hA5);
    use_model = 1'b0;

    // R9 writing ones keeps flags, writing zeros clears them
    wr_reg(1'b0, ctrl_cur | 8'h03);
    rd_reg(1'b0, rd);
    chk(rd[1:0] == 2'b11 && irq, "R9 ones keep flags", rd[1:0], 2'b11);
    wr_reg(1'b0, ctrl_cur);
    rd_reg(1'b0, rd);
    chk(rd[1:0] == 2'b00 && !irq, "R9 zeros clear flags", rd[1:0], 0);

    // R10 slave exchanges in both orders, select ignored
    for (int o = 0; o < 2; o++) begin
      set_cfg(cfg(1'b0, 2'd3, 1'b1, o[0], 1'b0));
      chk(sck_oe == 1'b0 && sdo_oe == 1'b1, "R2 slave pins", {sck_oe, sdo_oe}, 2'b01);
      ss_n_i = 1'b1;
      wr_reg(1'b1, 8'hB4);
      got = 8'h00;
      sbits(0, 8, 8'h2D, o[0], got);
      chk(irq == 1'b1, "R10 slave complete (R11 select ignored)", irq, 1);
      rd_reg(1'b1, rd);
      chk(rd == 8'h2D, "R10 slave received", rd, 8'h2D);
      chk(got == 8'hB4, "R10 slave transmitted", got, 8'hB4);
      set_cfg(ctrl_cur);
    end

    // R11 select qualification
    set_cfg(cfg(1'b0, 2'd3, 1'b1, 1'b1, 1'b1));
    ss_n_i = 1'b1;
    wr_reg(1'b1, 8'h77);
    got = 8'h00;
    sbits(0, 8, 8'h00, 1'b1, got);
    rd_reg(1'b1, rd);
    chk(rd == 8'h77 && !irq, "R11 deselected no shift", rd, 8'h77);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    sbits(0, 3, 8'hFF, 1'b1, got);
    ss_n_i = 1'b1;
    repeat (10) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    sbits(0, 5, 8'h96, 1'b1, got);
    chk(irq == 1'b0, "R11 partial count discarded", irq, 0);
    sbits(5, 3, 8'h96, 1'b1, got);
    chk(irq == 1'b1, "R11 complete after full byte", irq, 1);
    rd_reg(1'b1, rd);
    chk(rd == 8'h96, "R11 received after reselect", rd, 8'h96);

    // R2 disabling releases pins
    set_cfg(cfg(1'b0, 2'd0, 1'b0, 1'b1, 1'b0));
    chk(sck_oe == 1'b0 && sdo_oe == 1'b0, "R2 disabled pins", {sck_oe, sdo_oe}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule